// File: doc/BRIEF.md
# Windowed Signed Multiply-Accumulate Unit

This block multiplies two 16-bit two's complement operands and adds the 32-bit signed product into a 40-bit accumulator. The accumulator has eight guard bits above the product range. An external sequencer drives it through a command interface: a valid strobe, an opcode and the two operands. Multiply-accumulate and clear take several cycles, and a busy output marks the cycles during which further commands are dropped. Shift-left, arithmetic shift-right and window write finish in the cycle they are accepted.

The accumulator is too wide for a 16-bit data path, so software sees it through a 16-bit window. A 2-bit select places the window on one of four byte-aligned positions, both for reads (combinational) and for writes (a command). The product is formed in four sequential steps, each an 8x8 multiply of operand bytes. A sign flag records the sign of the latest sum. An overflow flag latches any two's complement overflow of the 40-bit sum, and further multiply-accumulates do not clear it.

Top module: `mac_window_unit`

## Requirements
- R1: After reset the accumulator is zero, and carry, ovf and busy are low.
- R2: A command accepted with opcode 3'b001 (multiply-accumulate) adds the signed product of opa and opb, each a 16-bit two's complement value, to the 40-bit accumulator, sign-extending the product.
- R3: A multiply-accumulate accepted at clock edge E0 raises busy for the next eight cycles. The accumulator takes the new sum at edge E8 and busy is low after E8, so the command occupies nine cycles in all.
- R4: Opcode 3'b010 (clear) zeroes all 40 accumulator bits and clears carry and ovf. Busy is high for the one cycle after acceptance, and the command occupies two cycles.
- R5: Opcode 3'b011 moves the accumulator left by one bit in the accepting cycle, loads 0 into bit 0, and leaves carry and ovf unchanged.
- R6: Opcode 3'b100 moves the accumulator right by one bit in the accepting cycle, copies bit 39 into the vacated top bit, and leaves the flags unchanged.
- R7: win_rdata shows accumulator bits 15:0, 23:8, 31:16 or 39:24 when win_sel is 0, 1, 2 or 3.
- R8: Opcode 3'b101 (window write) loads win_wdata into the 16 accumulator bits picked by win_sel as in R7, leaving the other 24 bits as they were.
- R9: After each multiply-accumulate, carry equals bit 39 of the new accumulator.
- R10: ovf is set when a multiply-accumulate sum overflows 40-bit two's complement. Later multiply-accumulates, shifts and window writes keep it set, and only reset or clear lowers it.
- R11: A command presented while busy is high is ignored and changes neither the accumulator nor the timing of the running command.
- R12: 256 products of (-32768)*(-32768) summed from zero give 2^38 and leave ovf low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when busy is low |
| cmd_op | input | 3 | Command opcode |
| opa | input | 16 | Signed multiplicand |
| opb | input | 16 | Signed multiplier |
| win_sel | input | 2 | Window position for read and write |
| win_wdata | input | 16 | Data for a window write |
| busy | output | 1 | A multi-cycle command is in progress |
| win_rdata | output | 16 | Selected 16 accumulator bits |
| carry | output | 1 | Sign of the accumulator after the latest multiply-accumulate |
| ovf | output | 1 | Sticky two's complement overflow |

## Verification
The multiply-accumulate runs over a grid of operands: both extremes, values next to byte boundaries (127, 128, 255, 256, -255, -256), plus and minus one, zero, and mixed bit patterns. This grid separates the sign handling of the four partial products, because each high/low byte pairing sees its own sign combination. A known pattern written through three windows and read back through all four shows whether windows overlap correctly and whether a write disturbs bits outside its window. Saturating sums near the top of the range separate a true sticky overflow from one recomputed on every operation, and a cycle-by-cycle probe of busy and the accumulator pins down the nine-cycle and two-cycle timing.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_NOP = 3'd0,
        OP_MAC = 3'd1,
        OP_CLR = 3'd2,
        OP_SHL = 3'd3,
        OP_ASR = 3'd4,
        OP_WRW = 3'd5
    } mac_op_e;

endpackage

// File: rtl/mac_byte_mult.sv
module mac_byte_mult #(
    parameter int OPW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [OPW-1:0]        a_in,
    input  logic [OPW-1:0]        b_in,
    output logic signed [2*OPW-1:0] prod,
    output logic                  done
);

    localparam int NB    = OPW / 8;
    localparam int NSTEP = NB * NB;
    localparam int SW    = (NSTEP > 1) ? $clog2(NSTEP) : 1;
    localparam int PW    = 2 * OPW;

    typedef struct packed {
        logic                 run;
        logic                 done;
        logic [SW-1:0]        step;
        logic [OPW-1:0]       a;
        logic [OPW-1:0]       b;
        logic signed [PW-1:0] sum;
    } mul_st_t;

    mul_st_t st_d, st_q;

    logic [7:0]           byte_a, byte_b;
    logic signed [8:0]    ext_a, ext_b;
    logic signed [17:0]   pp;
    logic signed [PW-1:0] pp_ext;
    logic signed [PW-1:0] pp_sh;

    always_comb begin
        int ia;
        int ib;
        ia     = int'(st_q.step) / NB;
        ib     = int'(st_q.step) % NB;
        byte_a = st_q.a[8*ia +: 8];
        byte_b = st_q.b[8*ib +: 8];
        // top byte carries the sign, lower bytes are magnitudes
        ext_a  = {(ia == NB-1) ? byte_a[7] : 1'b0, byte_a};
        ext_b  = {(ib == NB-1) ? byte_b[7] : 1'b0, byte_b};
        pp     = ext_a * ext_b;
        pp_ext = {{(PW-18){pp[17]}}, pp};
        pp_sh  = pp_ext <<< (8 * (ia + ib));

        st_d = st_q;
        if (start) begin
            st_d.a    = a_in;
            st_d.b    = b_in;
            st_d.sum  = '0;
            st_d.step = '0;
            st_d.run  = 1'b1;
            st_d.done = 1'b0;
        end else if (st_q.run) begin
            st_d.sum = st_q.sum + pp_sh;
            if (st_q.step == SW'(NSTEP-1)) begin
                st_d.run  = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.step = st_q.step + SW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prod = st_q.sum;
    assign done = st_q.done;

    AST_MUL_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (st_q.run && !st_q.done)); // R3
    AST_MUL_DONE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.done) |-> $past(st_q.run)); // R2

endmodule

// File: rtl/mac_window.sv
module mac_window #(
    parameter int ACCW = 40,
    parameter int WINW = 16,
    parameter int SELW = 2
) (
    input  logic [ACCW-1:0] acc,
    input  logic [SELW-1:0] sel,
    input  logic [WINW-1:0] wdata,
    output logic [WINW-1:0] rdata,
    output logic [ACCW-1:0] merged
);

    localparam int NPOS = 1 << SELW;
    localparam int STEP = (ACCW - WINW) / (NPOS - 1);

    logic [WINW-1:0] taps [NPOS];

    for (genvar p = 0; p < NPOS; p++) begin : g_tap
        assign taps[p] = acc[p*STEP +: WINW];
    end

    always_comb begin
        int lsb;
        lsb    = int'(sel) * STEP;
        rdata  = taps[sel];
        merged = acc;
        merged[lsb +: WINW] = wdata;
    end

endmodule

// File: rtl/mac_window_unit.sv
module mac_window_unit
    import mac_pkg::*;
#(
    parameter int OPW     = 16,
    parameter int ACCW    = 40,
    parameter int WINW    = 16,
    parameter int SELW    = 2,
    parameter int MAC_CYC = 9,
    parameter int CLR_CYC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_op,
    input  logic [OPW-1:0]  opa,
    input  logic [OPW-1:0]  opb,
    input  logic [SELW-1:0] win_sel,
    input  logic [WINW-1:0] win_wdata,
    output logic            busy,
    output logic [WINW-1:0] win_rdata,
    output logic            carry,
    output logic            ovf
);

    localparam int PW       = 2 * OPW;
    localparam int CNTW     = $clog2(MAC_CYC + 1);
    localparam int MAC_LAST = MAC_CYC - 1;
    localparam int CLR_LAST = CLR_CYC - 1;

    typedef struct packed {
        logic [ACCW-1:0] acc;
        logic            carry;
        logic            ovf;
        logic            busy;
        mac_op_e         op;
        logic [CNTW-1:0] cnt;
    } unit_st_t;

    unit_st_t st_d, st_q;

    logic                 accept;
    logic                 mul_start;
    logic                 mul_done;
    logic signed [PW-1:0] prod;
    logic [ACCW-1:0]      prod_ext;
    logic [ACCW-1:0]      sum_full;
    logic                 sum_ovf;
    logic [ACCW-1:0]      merged;
    logic                 fin;

    assign accept    = cmd_valid && !st_q.busy;
    assign mul_start = accept && (cmd_op == OP_MAC);

    mac_byte_mult #(.OPW(OPW)) i_mult (
        .clk   (clk),
        .rst_n (rst_n),
        .start (mul_start),
        .a_in  (opa),
        .b_in  (opb),
        .prod  (prod),
        .done  (mul_done)
    );

    mac_window #(.ACCW(ACCW), .WINW(WINW), .SELW(SELW)) i_win (
        .acc    (st_q.acc),
        .sel    (win_sel),
        .wdata  (win_wdata),
        .rdata  (win_rdata),
        .merged (merged)
    );

    always_comb begin
        prod_ext = {{(ACCW-PW){prod[PW-1]}}, prod};
        sum_full = st_q.acc + prod_ext;
        sum_ovf  = (st_q.acc[ACCW-1] == prod_ext[ACCW-1]) &&
                   (sum_full[ACCW-1] != st_q.acc[ACCW-1]);
        fin      = 1'b0;

        st_d = st_q;
        if (st_q.busy) begin
            st_d.cnt = st_q.cnt + CNTW'(1);
            if (st_q.op == OP_MAC && st_q.cnt == CNTW'(MAC_LAST)) begin
                fin         = 1'b1;
                st_d.acc    = sum_full;
                st_d.carry  = sum_full[ACCW-1];
                st_d.ovf    = st_q.ovf | sum_ovf;
                st_d.busy   = 1'b0;
                st_d.cnt    = '0;
            end else if (st_q.op == OP_CLR && st_q.cnt == CNTW'(CLR_LAST)) begin
                fin         = 1'b1;
                st_d.acc    = '0;
                st_d.carry  = 1'b0;
                st_d.ovf    = 1'b0;
                st_d.busy   = 1'b0;
                st_d.cnt    = '0;
            end
        end else if (cmd_valid) begin
            case (cmd_op)
                OP_MAC: begin
                    st_d.busy = 1'b1;
                    st_d.op   = OP_MAC;
                    st_d.cnt  = CNTW'(1);
                end
                OP_CLR: begin
                    st_d.busy = 1'b1;
                    st_d.op   = OP_CLR;
                    st_d.cnt  = CNTW'(1);
                end
                OP_SHL:  st_d.acc = {st_q.acc[ACCW-2:0], 1'b0};
                OP_ASR:  st_d.acc = {st_q.acc[ACCW-1], st_q.acc[ACCW-1:1]};
                OP_WRW:  st_d.acc = merged;
                default: st_d.acc = st_q.acc;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.op  <= OP_NOP;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy  = st_q.busy;
    assign carry = st_q.carry;
    assign ovf   = st_q.ovf;

    AST_PROD_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.op == OP_MAC && st_q.cnt == CNTW'(MAC_LAST)) |-> mul_done); // R3
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !fin) |=> ($stable(st_q.acc) && st_q.busy)); // R11
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.ovf) |-> ($past(st_q.op) == OP_CLR && $past(st_q.busy))); // R10
    AST_CARRY_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(st_q.busy) && $past(st_q.op) == OP_MAC) |-> (st_q.carry == st_q.acc[ACCW-1])); // R9
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(st_q.busy) && $past(st_q.op) == OP_CLR) |-> (st_q.acc == '0 && !st_q.ovf)); // R4

endmodule

// File: tb/test_mac_window_unit.sv
module test_mac_window_unit;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [15:0] opa = '0, opb = '0;
    logic [1:0]  win_sel = '0;
    logic [15:0] win_wdata = '0;
    logic        busy, carry, ovf;
    logic [15:0] win_rdata;

    int errors = 0;
    int checks = 0;
    longint model = 0;
    logic [39:0] accv;

    always #(CLK_P/2) clk = ~clk;

    mac_window_unit i_mac_window_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .opa(opa), .opb(opb), .win_sel(win_sel), .win_wdata(win_wdata),
        .busy(busy), .win_rdata(win_rdata), .carry(carry), .ovf(ovf)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic longint wrap40(input longint v);
        logic [39:0] t;
        t = v[39:0];
        return {{24{t[39]}}, t};
    endfunction

    task automatic read_acc(output logic [39:0] v);
        win_sel = 2'd0; #1; v[15:0]  = win_rdata;
        win_sel = 2'd2; #1; v[31:16] = win_rdata;
        win_sel = 2'd3; #1; v[39:32] = win_rdata[15:8];
    endtask

    task automatic issue(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                         input logic [1:0] sel, input logic [15:0] wd);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; opa = a; opb = b; win_sel = sel; win_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    task automatic check_acc(input string tag);
        read_acc(accv);
        chk(accv == model[39:0], tag, longint'(accv), model & 40'hFF_FFFF_FFFF);
    endtask

    task automatic do_mac(input int a, input int b);
        longint s;
        issue(3'd1, 16'(a), 16'(b), 2'd0, 16'd0);
        s = model + longint'(a) * longint'(b);
        model = wrap40(s);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int grid [14] = '{-32768, -32767, -256, -255, -1, 0, 1, 127, 128, 255, 256, 32767, 4660, -23130};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(carry == 1'b0, "R1 carry", carry, 0);
        chk(ovf == 1'b0, "R1 ovf", ovf, 0);
        check_acc("R1 acc");

        // R8 window writes build a pattern, R7 reads it back
        issue(3'd5, 0, 0, 2'd0, 16'h3210);
        issue(3'd5, 0, 0, 2'd2, 16'h7654);
        issue(3'd5, 0, 0, 2'd3, 16'hA976);
        model = wrap40(longint'(40'hA9_7654_3210));
        check_acc("R8 build");
        for (int s = 0; s < 4; s++) begin
            logic [15:0] exp;
            logic [39:0] m;
            m = model[39:0];
            exp = m[s*8 +: 16];
            win_sel = 2'(s); #1;
            chk(win_rdata == exp, $sformatf("R7 window %0d", s), win_rdata, exp);
        end
        issue(3'd5, 0, 0, 2'd1, 16'hBEEF);
        model = wrap40(longint'(40'hA9_76BE_EF10));
        check_acc("R8 window 1 write");

        // R6 arithmetic right on negative value, R5 left shift
        issue(3'd4, 0, 0, 2'd0, 0);
        model = model >>> 1;
        check_acc("R6 asr negative");
        chk(!carry && !ovf, "R6 flags", {carry, ovf}, 0);
        issue(3'd5, 0, 0, 2'd3, 16'h4000);
        model = wrap40((model & 40'h00_00FF_FFFF) | longint'(40'h40_0000_0000));
        issue(3'd4, 0, 0, 2'd0, 0);
        model = model >>> 1;
        check_acc("R6 asr positive");
        issue(3'd3, 0, 0, 2'd0, 0);
        model = wrap40(model << 1);
        check_acc("R5 shl");
        issue(3'd3, 0, 0, 2'd0, 0);
        model = wrap40(model << 1);
        check_acc("R5 shl into sign");
        chk(!carry && !ovf, "R5 flags", {carry, ovf}, 0);

        // R4 clear timing
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd2;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == 1'b1, "R4 busy after accept", busy, 1);
        @(negedge clk);
        chk(busy == 1'b0, "R4 done in two cycles", busy, 0);
        model = 0;
        check_acc("R4 acc zero");

        // R3 timing with R11 ignored command mid-flight
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd1; opa = 16'(300); opb = 16'(-7);
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int k = 1; k <= 8; k++) begin
            chk(busy == 1'b1, $sformatf("R3 busy cycle %0d", k), busy, 1);
            if (k == 3) begin
                cmd_valid = 1'b1; cmd_op = 3'd5; win_sel = 2'd0; win_wdata = 16'h5555;
            end
            if (k == 4) begin
                cmd_valid = 1'b1; cmd_op = 3'd2;
            end
            if (k == 5) cmd_valid = 1'b0;
            if (k == 8) check_acc("R3 acc held before update");
            @(negedge clk);
        end
        chk(busy == 1'b0, "R3 busy low after edge 8", busy, 0);
        model = -2100;
        check_acc("R11 ignored commands, R3 result");

        // R2 / R9 sweep
        issue(3'd2, 0, 0, 2'd0, 0);
        model = 0;
        foreach (grid[i]) begin
            foreach (grid[j]) begin
                do_mac(grid[i], grid[j]);
                read_acc(accv);
                chk(accv == model[39:0], $sformatf("R2 mac %0d*%0d", grid[i], grid[j]),
                    longint'(accv), model & 40'hFF_FFFF_FFFF);
                chk(carry == accv[39], "R9 carry sign", carry, accv[39]);
                chk(ovf == 1'b0, "R2 no overflow", ovf, 0);
            end
        end

        // R12 guard bits
        issue(3'd2, 0, 0, 2'd0, 0);
        model = 0;
        for (int n = 0; n < 256; n++) do_mac(-32768, -32768);
        chk(model == (longint'(1) << 38), "R12 model", model, longint'(1) << 38);
        check_acc("R12 sum");
        chk(ovf == 1'b0, "R12 ovf low", ovf, 0);

        // R10 overflow, stickiness, clear
        issue(3'd2, 0, 0, 2'd0, 0);
        issue(3'd5, 0, 0, 2'd0, 16'hFFFF);
        issue(3'd5, 0, 0, 2'd2, 16'hFFFF);
        issue(3'd5, 0, 0, 2'd3, 16'h7FFF);
        model = longint'(40'h7F_FFFF_FFFF);
        do_mac(32767, 32767);
        check_acc("R10 wrapped sum");
        chk(ovf == 1'b1, "R10 ovf set", ovf, 1);
        chk(carry == 1'b1, "R9 carry after wrap", carry, 1);
        do_mac(0, 0);
        chk(ovf == 1'b1, "R10 sticky after mac", ovf, 1);
        do_mac(-1, 1);
        chk(ovf == 1'b1, "R10 sticky after second mac", ovf, 1);
        issue(3'd3, 0, 0, 2'd0, 0);
        chk(ovf == 1'b1, "R10 sticky after shift", ovf, 1);
        issue(3'd2, 0, 0, 2'd0, 0);
        chk(ovf == 1'b0, "R10 clear lowers ovf", ovf, 0);
        chk(carry == 1'b0, "R4 clear lowers carry", carry, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule